// File: doc/BRIEF.md
# In-Order Retirement Buffer with Register Renaming

This block is a circular buffer of in-flight instructions. The issue stage claims one slot per cycle, in program order, and receives the slot's tag back. Each slot records four things: the kind of instruction (register writer, store or branch), a register index, a data word and a completion flag. When an execution unit broadcasts a result on the result bus with a tag, the data word of that slot is filled in and the slot is marked complete. For a store, the data word is the effective address and the register index names the register that holds the store data. For a branch, bit 0 of the data word is the resolved outcome.

The oldest slot retires once it is complete, with at most one retirement per cycle. A retiring register writer drives the architectural register write port. A retiring store starts a cache write that then occupies the next two cycles, and the store's data register is read from architectural state at that moment. A retiring branch reports its outcome. Branch prediction is taken as perfect, so nothing is flushed.

A rename table maps each architectural register to the newest in-flight slot that will write it. A lookup port returns that mapping together with the slot's completion flag and value, so the issue stage can forward a finished result or wait on a tag. Retirement is governed by a small state machine with three states:
- `CS_IDLE`: no cache write is in progress.
- `CS_WR1`: the first cycle of a store's cache write.
- `CS_WR2`: the second cycle of that write.

Its transitions are: `CS_IDLE` to `CS_WR1` when a store retires, `CS_WR1` to `CS_WR2` unconditionally, and `CS_WR2` to `CS_IDLE` unconditionally.

Top module: `rob_commit_unit`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, `mem_busy` is 0, no retirement strobe is high and `lk_pending` is 0 for every register.
- R2: Tags are handed out in sequence. A cycle with `alloc_valid` and `alloc_ready` both high claims the tag shown on `alloc_tag`, and `alloc_tag` then advances by one modulo DEPTH. In any other cycle `alloc_tag` holds its value.
- R3: Once DEPTH slots are in flight, `alloc_ready` is 0. An `alloc_valid` seen while `alloc_ready` is 0 creates no slot and does not advance `alloc_tag`.
- R4: Retirement follows allocation order, at most one slot per cycle. A complete slot that sits behind an incomplete oldest slot waits.
- R5: A slot written on the result bus in cycle T can retire no earlier than cycle T+1.
- R6: A retiring register writer (`alloc_kind` 0) raises `rf_we` for one cycle, with `rf_addr` set to its register index and `rf_data` set to its value. When `rf_we` is 0, both `rf_addr` and `rf_data` are 0.
- R7: A retiring store (`alloc_kind` 1) raises `mem_wr_start` for one cycle, with `mem_wr_addr` set to its value and `mem_wr_src` set to its register index. `mem_busy` is then 1 for exactly the next two cycles.
- R8: While `mem_busy` is 1, a complete store at the head does not retire. It retires in the first cycle in which `mem_busy` is 0.
- R9: A retiring branch (`alloc_kind` 2) raises `br_retire` for one cycle. `br_taken` is bit 0 of its value. A branch never writes a register.
- R10: Looking up a register whose newest in-flight writer is slot t gives `lk_pending` 1 and `lk_tag` t. A later writer of the same register replaces the mapping in the cycle after its allocation. Stores and branches leave the mapping unchanged.
- R11: `lk_done` and `lk_value` show the completion flag and value of the mapped slot. Both are 0 when `lk_pending` is 0.
- R12: When a register writer retires, the mapping for its register is cleared only if it still names that slot. A mapping that names a newer slot stays in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue stage requests a slot |
| alloc_kind | input | 2 | 0 register writer, 1 store, 2 branch |
| alloc_dest | input | AREG_W | Destination register, or the store data register |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | TAG_W | Tag of the slot the next allocation claims |
| bus_valid | input | 1 | Result bus write |
| bus_tag | input | TAG_W | Slot the result belongs to |
| bus_value | input | DATA_W | Result, effective address or branch outcome |
| lk_reg | input | AREG_W | Register to look up |
| lk_pending | output | 1 | Register has an in-flight writer |
| lk_tag | output | TAG_W | Tag of the newest writer |
| lk_done | output | 1 | That writer is complete |
| lk_value | output | DATA_W | That writer's value |
| rf_we | output | 1 | Architectural register write |
| rf_addr | output | AREG_W | Register written |
| rf_data | output | DATA_W | Data written |
| mem_wr_start | output | 1 | Store retires and its cache write starts |
| mem_wr_addr | output | DATA_W | Store effective address |
| mem_wr_src | output | AREG_W | Register holding the store data |
| mem_busy | output | 1 | Two-cycle cache write in progress |
| br_retire | output | 1 | Branch retires |
| br_taken | output | 1 | Outcome of the retiring branch |

## Verification
On every cycle the assertions check the following:
- There is never more than one retirement strobe.
- A store start is followed by exactly two busy cycles, and no store starts while the cache write is busy.
- A full buffer stays full until something retires.
- The tag advances only when an allocation is accepted.
- A register-writer allocation shows up in the rename lookup one cycle later.

Some behaviour depends on history and only the bench's scenarios can show it. This covers results arriving out of order behind an incomplete head, the one-cycle gap between a bus write and retirement, a second store waiting out the busy window, a rejected allocation while the buffer is full, and a rename mapping that survives the retirement of an older writer. The bench's behavioural model compares all of these cycle by cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_WR1  = 2'd1,
        CS_WR2  = 2'd2
    } cstate_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic             commit_fire,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full,
    output logic             empty
);

    logic [TAG_W-1:0] head_q;
    logic [TAG_W-1:0] tail_q;
    logic             full_q;
    logic [TAG_W-1:0] tail_inc;

    assign tail_inc = tail_q + 1'b1;

    // DEPTH must be a power of two so that the pointers wrap on their own.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (alloc_fire) begin
                tail_q <= tail_inc;
            end
            if (commit_fire) begin
                head_q <= head_q + 1'b1;
            end
            if (alloc_fire && !commit_fire && (tail_inc == head_q)) begin
                full_q <= 1'b1;
            end else if (commit_fire && !alloc_fire) begin
                full_q <= 1'b0;
            end
        end
    end

    assign head  = head_q;
    assign tail  = tail_q;
    assign full  = full_q;
    assign empty = (head_q == tail_q) && !full_q;

endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 4,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_fire,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  kind_e             alloc_kind,
    input  logic [AREG_W-1:0] alloc_dest,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic              commit_fire,
    input  logic [TAG_W-1:0]  head_tag,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              head_done,
    output kind_e             head_kind,
    output logic [AREG_W-1:0] head_dest,
    output logic [DATA_W-1:0] head_value,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_value
);

    logic              done_a  [DEPTH];
    kind_e             kind_a  [DEPTH];
    logic [AREG_W-1:0] dest_a  [DEPTH];
    logic [DATA_W-1:0] value_a [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic              v_q;
        logic              d_q;
        kind_e             k_q;
        logic [AREG_W-1:0] r_q;
        logic [DATA_W-1:0] x_q;
        logic              hit_alloc;
        logic              hit_bus;
        logic              hit_commit;

        assign hit_alloc  = alloc_fire && (alloc_tag == TAG_W'(g));
        assign hit_bus    = bus_valid && (bus_tag == TAG_W'(g)) && v_q;
        assign hit_commit = commit_fire && (head_tag == TAG_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                k_q <= KIND_REG;
                r_q <= '0;
                x_q <= '0;
            end else begin
                if (hit_commit) begin
                    v_q <= 1'b0;
                end
                if (hit_bus) begin
                    d_q <= 1'b1;
                    x_q <= bus_value;
                end
                if (hit_alloc) begin
                    v_q <= 1'b1;
                    d_q <= 1'b0;
                    k_q <= alloc_kind;
                    r_q <= alloc_dest;
                    x_q <= '0;
                end
            end
        end

        assign done_a[g]  = d_q;
        assign kind_a[g]  = k_q;
        assign dest_a[g]  = r_q;
        assign value_a[g] = x_q;
    end

    assign head_done  = done_a[head_tag];
    assign head_kind  = kind_a[head_tag];
    assign head_dest  = dest_a[head_tag];
    assign head_value = value_a[head_tag];
    assign rd_done    = done_a[rd_tag];
    assign rd_value   = value_a[rd_tag];

endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
    parameter int NUM_AREG = 32,
    parameter int AREG_W   = 5,
    parameter int TAG_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [AREG_W-1:0] set_reg,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              clr_en,
    input  logic [AREG_W-1:0] clr_reg,
    input  logic [TAG_W-1:0]  clr_tag,
    input  logic [AREG_W-1:0] lk_reg,
    output logic              lk_hit,
    output logic [TAG_W-1:0]  lk_tag
);

    logic             map_v [NUM_AREG];
    logic [TAG_W-1:0] map_t [NUM_AREG];

    for (genvar r = 0; r < NUM_AREG; r++) begin : g_map
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic             do_set;
        logic             do_clr;

        assign do_set = set_en && (set_reg == AREG_W'(r));
        assign do_clr = clr_en && (clr_reg == AREG_W'(r)) && (t_q == clr_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else if (do_set) begin
                v_q <= 1'b1;
                t_q <= set_tag;
            end else if (do_clr) begin
                v_q <= 1'b0;
            end
        end

        assign map_v[r] = v_q;
        assign map_t[r] = t_q;
    end

    assign lk_hit = map_v[lk_reg];
    assign lk_tag = map_t[lk_reg];

endmodule

// File: rtl/rob_commit_ctl.sv
module rob_commit_ctl
    import rob_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  head_valid,
    input  logic  head_done,
    input  kind_e head_kind,
    output logic  commit_fire,
    output logic  rf_we,
    output logic  st_start,
    output logic  br_retire,
    output logic  mem_busy
);

    cstate_e state_q;
    cstate_e state_d;
    logic    can_retire;

    assign can_retire = head_valid && head_done &&
                        !((head_kind == KIND_STORE) && (state_q != CS_IDLE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: begin
                if (can_retire && (head_kind == KIND_STORE)) begin
                    state_d = CS_WR1;
                end
            end
            CS_WR1:  state_d = CS_WR2;
            CS_WR2:  state_d = CS_IDLE;
            default: state_d = CS_IDLE;
        endcase
    end

    always_comb begin
        commit_fire = can_retire;
        rf_we       = can_retire && (head_kind == KIND_REG);
        st_start    = can_retire && (head_kind == KIND_STORE);
        br_retire   = can_retire && (head_kind == KIND_BRANCH);
        mem_busy    = (state_q != CS_IDLE);
    end

endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit
    import rob_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int NUM_AREG = 32,
    parameter int DATA_W   = 32,
    localparam int TAG_W   = $clog2(DEPTH),
    localparam int AREG_W  = $clog2(NUM_AREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [AREG_W-1:0] alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    input  logic [AREG_W-1:0] lk_reg,
    output logic              lk_pending,
    output logic [TAG_W-1:0]  lk_tag,
    output logic              lk_done,
    output logic [DATA_W-1:0] lk_value,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_data,
    output logic              mem_wr_start,
    output logic [DATA_W-1:0] mem_wr_addr,
    output logic [AREG_W-1:0] mem_wr_src,
    output logic              mem_busy,
    output logic              br_retire,
    output logic              br_taken
);

    logic              alloc_fire;
    logic              commit_fire;
    logic [TAG_W-1:0]  head;
    logic [TAG_W-1:0]  tail;
    logic              full;
    logic              empty;
    kind_e             kind_in;
    logic              head_done;
    kind_e             head_kind;
    logic [AREG_W-1:0] head_dest;
    logic [DATA_W-1:0] head_value;
    logic              rd_done;
    logic [DATA_W-1:0] rd_value;
    logic              map_hit;
    logic [TAG_W-1:0]  map_tag;
    logic              rf_we_i;
    logic              st_start_i;
    logic              br_i;

    assign kind_in    = kind_e'(alloc_kind);
    assign alloc_fire = alloc_valid && !full;

    rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W)) ptrs_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire(alloc_fire), .commit_fire(commit_fire),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    rob_entries #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AREG_W(AREG_W), .DATA_W(DATA_W)) ent_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire(alloc_fire), .alloc_tag(tail), .alloc_kind(kind_in), .alloc_dest(alloc_dest),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .commit_fire(commit_fire), .head_tag(head), .rd_tag(map_tag),
        .head_done(head_done), .head_kind(head_kind), .head_dest(head_dest),
        .head_value(head_value), .rd_done(rd_done), .rd_value(rd_value)
    );

    rob_rename #(.NUM_AREG(NUM_AREG), .AREG_W(AREG_W), .TAG_W(TAG_W)) ren_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(alloc_fire && (kind_in == KIND_REG)), .set_reg(alloc_dest), .set_tag(tail),
        .clr_en(rf_we_i), .clr_reg(head_dest), .clr_tag(head),
        .lk_reg(lk_reg), .lk_hit(map_hit), .lk_tag(map_tag)
    );

    rob_commit_ctl ctl_i (
        .clk(clk), .rst_n(rst_n),
        .head_valid(!empty), .head_done(head_done), .head_kind(head_kind),
        .commit_fire(commit_fire), .rf_we(rf_we_i), .st_start(st_start_i),
        .br_retire(br_i), .mem_busy(mem_busy)
    );

    assign alloc_ready  = !full;
    assign alloc_tag    = tail;

    assign lk_pending   = map_hit;
    assign lk_tag       = map_hit ? map_tag : '0;
    assign lk_done      = map_hit && rd_done;
    assign lk_value     = map_hit ? rd_value : '0;

    assign rf_we        = rf_we_i;
    assign rf_addr      = rf_we_i ? head_dest : '0;
    assign rf_data      = rf_we_i ? head_value : '0;
    assign mem_wr_start = st_start_i;
    assign mem_wr_addr  = st_start_i ? head_value : '0;
    assign mem_wr_src   = st_start_i ? head_dest : '0;
    assign br_retire    = br_i;
    assign br_taken     = br_i && head_value[0];

endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk #(
    parameter int TAG_W  = 4,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic [1:0]        alloc_kind,
    input logic [AREG_W-1:0] alloc_dest,
    input logic              alloc_ready,
    input logic [TAG_W-1:0]  alloc_tag,
    input logic [AREG_W-1:0] lk_reg,
    input logic              lk_pending,
    input logic [TAG_W-1:0]  lk_tag,
    input logic              rf_we,
    input logic [AREG_W-1:0] rf_addr,
    input logic [DATA_W-1:0] rf_data,
    input logic              mem_wr_start,
    input logic              mem_busy,
    input logic              br_retire
);

    // R4
    one_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, mem_wr_start, br_retire}));

    // R7
    store_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_start |=> mem_busy ##1 mem_busy ##1 !mem_busy);

    // R8
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_busy |-> !mem_wr_start);

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !(rf_we || mem_wr_start || br_retire)) |=> !alloc_ready);

    // R2
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> (alloc_tag == TAG_W'($past(alloc_tag) + 1'b1)));

    // R2
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_valid && alloc_ready) |=> $stable(alloc_tag));

    // R10
    rename_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && (alloc_kind == 2'd0) && (alloc_dest == lk_reg))
        |=> ((lk_reg != $past(lk_reg)) || (lk_pending && (lk_tag == $past(alloc_tag)))));

    // R6
    rf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_we |-> ((rf_addr == '0) && (rf_data == '0)));

endmodule

bind rob_commit_unit rob_commit_chk #(.TAG_W(TAG_W), .AREG_W(AREG_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .lk_reg(lk_reg), .lk_pending(lk_pending), .lk_tag(lk_tag),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .mem_wr_start(mem_wr_start), .mem_busy(mem_busy), .br_retire(br_retire)
);

// File: tb/rob_commit_unit_tb.sv
module rob_commit_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int NREG       = 32;
    localparam int TW         = 4;
    localparam int RW         = 5;

    typedef struct {
        int       tag;
        int       kind;
        int       dest;
        bit [31:0] value;
        bit       done;
    } ment_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [1:0]    alloc_kind = '0;
    logic [RW-1:0] alloc_dest = '0;
    logic          alloc_ready;
    logic [TW-1:0] alloc_tag;
    logic          bus_valid = 1'b0;
    logic [TW-1:0] bus_tag = '0;
    logic [31:0]   bus_value = '0;
    logic [RW-1:0] lk_reg = '0;
    logic          lk_pending;
    logic [TW-1:0] lk_tag;
    logic          lk_done;
    logic [31:0]   lk_value;
    logic          rf_we;
    logic [RW-1:0] rf_addr;
    logic [31:0]   rf_data;
    logic          mem_wr_start;
    logic [31:0]   mem_wr_addr;
    logic [RW-1:0] mem_wr_src;
    logic          mem_busy;
    logic          br_retire;
    logic          br_taken;

    int checks = 0;
    int errors = 0;

    // Staged stimulus, copied to the ports at each falling edge.
    bit        s_av;
    int        s_ak;
    int        s_ad;
    bit        s_bv;
    int        s_bt;
    bit [31:0] s_bx;
    int        s_lk;

    // Behavioural model state.
    ment_t q[$];
    int    next_tag = 0;
    int    busy = 0;
    int    map_t[NREG];

    rob_commit_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .lk_reg(lk_reg), .lk_pending(lk_pending), .lk_tag(lk_tag),
        .lk_done(lk_done), .lk_value(lk_value),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .mem_wr_start(mem_wr_start), .mem_wr_addr(mem_wr_addr), .mem_wr_src(mem_wr_src),
        .mem_busy(mem_busy), .br_retire(br_retire), .br_taken(br_taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic clear_stage();
        s_av = 0; s_ak = 0; s_ad = 0; s_bv = 0; s_bt = 0; s_bx = '0;
    endtask

    // Compare all outputs with the model, then advance the model one clock.
    task automatic cyc();
        bit fire;
        bit rdy;
        int k;
        int t;
        bit pend;
        bit e_done;
        bit [31:0] e_val;
        ment_t h;
        ment_t n;
        @(negedge clk);
        alloc_valid = s_av; alloc_kind = 2'(s_ak); alloc_dest = RW'(s_ad);
        bus_valid = s_bv; bus_tag = TW'(s_bt); bus_value = s_bx; lk_reg = RW'(s_lk);
        #1;
        rdy  = (q.size() < DEPTH);
        fire = 0;
        k    = -1;
        if (q.size() > 0) begin
            h = q[0];
            k = h.kind;
            fire = h.done && !(h.kind == 1 && busy > 0);
            // R5: a slot written this very cycle must not retire yet.
            if (s_bv && h.tag == s_bt && !h.done)
                chk(!(rf_we || mem_wr_start || br_retire), "R5 retire in bus-write cycle",
                    rf_we || mem_wr_start || br_retire, 0);
        end
        chk(alloc_ready == rdy, "R3 alloc_ready", alloc_ready, rdy);
        chk(alloc_tag == TW'(next_tag), "R2 alloc_tag", alloc_tag, next_tag);
        chk((rf_we || mem_wr_start || br_retire) == fire, "R4 retire strobe",
            rf_we || mem_wr_start || br_retire, fire);
        chk(rf_we == (fire && k == 0), "R6 rf_we", rf_we, fire && k == 0);
        chk(rf_addr == ((fire && k == 0) ? RW'(h.dest) : '0), "R6 rf_addr", rf_addr,
            (fire && k == 0) ? h.dest : 0);
        chk(rf_data == ((fire && k == 0) ? h.value : 32'd0), "R6 rf_data", rf_data,
            (fire && k == 0) ? h.value : 0);
        chk(mem_wr_start == (fire && k == 1), "R7 mem_wr_start", mem_wr_start, fire && k == 1);
        if (fire && k == 1) begin
            chk(mem_wr_addr == h.value, "R7 mem_wr_addr", mem_wr_addr, h.value);
            chk(mem_wr_src == RW'(h.dest), "R7 mem_wr_src", mem_wr_src, h.dest);
        end
        chk(mem_busy == (busy > 0), "R8 mem_busy", mem_busy, busy > 0);
        chk(br_retire == (fire && k == 2), "R9 br_retire", br_retire, fire && k == 2);
        chk(br_taken == (fire && k == 2 && h.value[0]), "R9 br_taken", br_taken,
            fire && k == 2 && h.value[0]);
        t = map_t[s_lk];
        pend = (t >= 0);
        e_done = 0;
        e_val = '0;
        foreach (q[i]) if (pend && q[i].tag == t) begin e_done = q[i].done; e_val = q[i].value; end
        chk(lk_pending == pend, "R10 R12 lk_pending", lk_pending, pend);
        chk(lk_tag == (pend ? TW'(t) : '0), "R10 R12 lk_tag", lk_tag, pend ? t : 0);
        chk(lk_done == e_done, "R11 lk_done", lk_done, e_done);
        chk(lk_value == e_val, "R11 lk_value", lk_value, e_val);
        // Next state of the model.
        if (fire) begin
            h = q.pop_front();
            if (h.kind == 0 && map_t[h.dest] == h.tag) map_t[h.dest] = -1;
        end
        if (fire && k == 1) busy = 2;
        else if (busy > 0) busy--;
        if (s_bv) foreach (q[i]) if (q[i].tag == s_bt) begin q[i].done = 1; q[i].value = s_bx; end
        if (s_av && rdy) begin
            n.tag = next_tag; n.kind = s_ak; n.dest = s_ad; n.value = '0; n.done = 0;
            q.push_back(n);
            if (s_ak == 0) map_t[s_ad] = next_tag;
            next_tag = (next_tag + 1) % DEPTH;
        end
    endtask

    task automatic do_alloc(input int kind, input int dest);
        clear_stage(); s_av = 1; s_ak = kind; s_ad = dest; cyc();
    endtask

    task automatic do_bus(input int tag, input bit [31:0] val);
        clear_stage(); s_bv = 1; s_bt = tag; s_bx = val; cyc();
    endtask

    task automatic idle(input int n);
        clear_stage();
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R4 watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int tags[DEPTH];
        int nt;
        for (int r = 0; r < NREG; r++) map_t[r] = -1;
        clear_stage();
        s_lk = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(alloc_ready == 1'b1, "R1 alloc_ready after reset", alloc_ready, 1);
        chk(alloc_tag == '0, "R1 alloc_tag after reset", alloc_tag, 0);
        chk(mem_busy == 1'b0, "R1 mem_busy after reset", mem_busy, 0);
        chk(!(rf_we || mem_wr_start || br_retire), "R1 no retire after reset",
            rf_we || mem_wr_start || br_retire, 0);
        chk(lk_pending == 1'b0, "R1 lk_pending after reset", lk_pending, 0);
        idle(2);

        // Mixed program: out-of-order results, back-to-back stores, branch, rename override.
        do_alloc(0, 1);
        do_alloc(0, 2);
        do_alloc(1, 3);
        do_alloc(1, 4);
        do_alloc(2, 0);
        do_alloc(0, 1);
        do_bus(1, 32'h11);
        do_bus(0, 32'h10);
        do_bus(3, 32'h300);
        do_bus(2, 32'h200);
        do_bus(4, 32'h1);
        do_bus(5, 32'h55);
        idle(12);
        // R12: the newer writer of register 1 has retired too, so the map is clear.
        #1;
        chk(lk_pending == 1'b0, "R12 map cleared by its own writer", lk_pending, 0);

        // Fill the buffer, try one more, then complete in reverse order.
        s_lk = 3;
        for (int i = 0; i < DEPTH + 1; i++) do_alloc(0, i % 8);
        chk(alloc_ready == 1'b0, "R3 full after DEPTH allocations", alloc_ready, 0);
        nt = q.size();
        foreach (q[i]) tags[i] = q[i].tag;
        for (int i = nt - 1; i >= 0; i--) do_bus(tags[i], 32'(100 + i));
        idle(DEPTH + 4);

        // Branch not taken, then a store with a register writer after it.
        do_alloc(2, 0);
        do_alloc(1, 6);
        do_alloc(0, 6);
        do_bus(q[0].tag, 32'h0);
        do_bus(q[1].tag, 32'h640);
        do_bus(q[1].tag, 32'h77);
        idle(6);

        // Random traffic.
        void'($urandom(7));
        for (int c = 0; c < 600; c++) begin
            clear_stage();
            s_lk = $urandom_range(0, 7);
            if ($urandom_range(0, 2) != 0) begin
                s_av = 1; s_ak = $urandom_range(0, 2); s_ad = $urandom_range(0, 7);
            end
            if (q.size() > 0 && $urandom_range(0, 9) < 7) begin
                int j;
                j = $urandom_range(0, q.size() - 1);
                if (!q[j].done) begin s_bv = 1; s_bt = q[j].tag; s_bx = $urandom; end
            end
            cyc();
        end
        clear_stage();
        for (int c = 0; c < 3 * DEPTH && q.size() > 0; c++) begin
            clear_stage();
            foreach (q[i]) if (!q[i].done && !s_bv) begin s_bv = 1; s_bt = q[i].tag; s_bx = 32'(c); end
            cyc();
        end
        idle(8);
        chk(q.size() == 0, "R4 buffer drained", q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule